// File: doc/BRIEF.md
# Byte-Accessed 16-bit Timer with Dual Compare

This block is a 16-bit up-counter with two 16-bit compare channels. An 8-bit register bus is its only way in. Each channel raises a sticky match flag and toggles its own waveform pin when the counter reaches its compare value. Counting advances only on cycles where the `tick` enable is high, so the prescaler sits outside the block.

Every 16-bit value crosses the byte bus in one piece through a single shared staging byte.

- **Writes:** software writes the high byte first, which parks it in the staging byte. The low-byte write then commits all 16 bits in one cycle.
- **Reads of the counter:** reading the low byte copies the counter's high half into the staging byte in the same cycle. A later high-byte read returns that copy, so the two bytes always belong to one counter value.

An optional mode makes compare channel A the top of the count. Software strobes can toggle either waveform pin without a real match.

Register map, as 3-bit byte addresses:

| Address | Contents |
|---|---|
| 0 | counter low byte |
| 1 | counter high byte |
| 2 | compare A low byte |
| 3 | compare A high byte |
| 4 | compare B low byte |
| 5 | compare B high byte |
| 6 | control |
| 7 | flags |

Top module: `byte_timer16`

## Requirements
- R1: After reset the counter, both compare registers, the control mode bit, both flags and both waveform outputs are zero.
- R2: A write to a high-byte address (1, 3, 5) changes only the staging byte. A write to a low-byte address (0, 2, 4) loads {staging byte, written byte} into that 16-bit register, visible from the next cycle.
- R3: Reading address 0 returns the counter's low byte and copies its high byte into the staging byte. Reading address 1 returns the staging byte, even if the counter has moved since. Compare bytes read back directly.
- R4: The staging byte is shared: whatever last loaded it (a high-byte write or a counter low-byte read) becomes the upper half of the next low-byte write to any register.
- R5: In normal mode (control bit 0 = 0) each tick adds one to the counter, and 0xFFFF rolls over to 0x0000.
- R6: In top mode (control bit 0 = 1), a tick on which the counter equals compare A sets the counter to 0 instead of incrementing it.
- R7: A tick on which the counter equals a channel's compare value sets that channel's flag (flag register bit 0 = A, bit 1 = B) and toggles its waveform output, both seen the following cycle.
- R8: After any counter load, the next tick produces no compare match on either channel. This includes the top-mode clear. The counter still advances on that tick.
- R9: Writing 1 to control bit 1 (A) or bit 2 (B) toggles that channel's waveform output. It sets no flag and leaves the counter unchanged, even in top mode.
- R10: Reading control returns the mode in bit 0; the strobe bits 1 and 2 always read as zero.
- R11: Writing 1 to a flag bit clears it; writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer count enable, one clock wide per step |
| bus_addr | input | 3 | Byte register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (triggers staging capture at address 0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed byte |
| cmp_flag | output | 2 | Sticky match flags, bit 0 = A, bit 1 = B |
| cmp_wave | output | 2 | Toggling waveform outputs, bit 0 = A, bit 1 = B |

## Verification
The hardest case to reach is the match that a counter load suppresses. It needs two things at once:

- the counter is loaded with a value equal to a compare register;
- a tick follows immediately, so the suppressed compare would otherwise fire.

The bench loads the counter with compare A's value and gives exactly one tick. It then checks that the flag and pin of A are unchanged. The second tick lands on compare B's value and must match, which shows the block lasts only one tick. The same load-then-tick sequence in top mode shows that the counter clear is suppressed as well.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int ADDR_W = 3;
  localparam int NCH    = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_CNT_LO  = 3'd0,
    RA_CNT_HI  = 3'd1,
    RA_CMPA_LO = 3'd2,
    RA_CMPA_HI = 3'd3,
    RA_CMPB_LO = 3'd4,
    RA_CMPB_HI = 3'd5,
    RA_CTRL    = 3'd6,
    RA_FLAG    = 3'd7
  } reg_addr_e;

  localparam int CTRL_MODE_BIT  = 0;
  localparam int CTRL_FORCE_LSB = 1;
endpackage

// File: rtl/tmr_bus_if.sv
module tmr_bus_if
  import tmr_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int NC = NCH,
  localparam int WW = 2 * BW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [BW-1:0]        bus_wdata,
  output logic [BW-1:0]        bus_rdata,
  input  logic [WW-1:0]        cnt_val,
  input  logic [NC-1:0][WW-1:0] cmp_val,
  input  logic [NC-1:0]        flag_val,
  output logic [WW-1:0]        word_val,
  output logic                 cnt_ld,
  output logic [NC-1:0]        cmp_ld,
  output logic [NC-1:0]        force_stb,
  output logic [NC-1:0]        flag_clr,
  output logic                 mode_top
);
  localparam logic [ADDR_W-1:0] CMP_END = ADDR_W'(2 + 2 * NC);

  logic [BW-1:0] temp_q, temp_d;
  logic          mode_q, mode_d;
  logic          hi_wr, cnt_lo_rd, ctrl_wr;

  assign hi_wr     = bus_wr && bus_addr[0] && (bus_addr < CMP_END);
  assign cnt_lo_rd = bus_rd && (bus_addr == RA_CNT_LO);
  assign ctrl_wr   = bus_wr && (bus_addr == RA_CTRL);
  assign cnt_ld    = bus_wr && (bus_addr == RA_CNT_LO);
  assign word_val  = {temp_q, bus_wdata};
  assign mode_top  = mode_q;

  for (genvar i = 0; i < NC; i++) begin : g_ch_dec
    assign cmp_ld[i]    = bus_wr && (bus_addr == ADDR_W'(2 + 2 * i));
    assign force_stb[i] = ctrl_wr && bus_wdata[CTRL_FORCE_LSB + i];
    assign flag_clr[i]  = bus_wr && (bus_addr == RA_FLAG) && bus_wdata[i];
  end

  always_comb begin
    temp_d = temp_q;
    if (hi_wr)          temp_d = bus_wdata;
    else if (cnt_lo_rd) temp_d = cnt_val[WW-1:BW];
  end

  always_comb begin
    mode_d = mode_q;
    if (ctrl_wr) mode_d = bus_wdata[CTRL_MODE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q <= '0;
      mode_q <= 1'b0;
    end else begin
      temp_q <= temp_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_CNT_LO: bus_rdata = cnt_val[BW-1:0];
      RA_CNT_HI: bus_rdata = temp_q;
      RA_CTRL:   bus_rdata = BW'(mode_q);
      RA_FLAG:   bus_rdata = BW'(flag_val);
      default: begin
        for (int i = 0; i < NC; i++) begin
          if (bus_addr == ADDR_W'(2 + 2 * i)) bus_rdata = cmp_val[i][BW-1:0];
          if (bus_addr == ADDR_W'(3 + 2 * i)) bus_rdata = cmp_val[i][WW-1:BW];
        end
      end
    endcase
  end

  AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_wr && !cnt_lo_rd) |=> $stable(temp_q)); // R3

  AST_HI_WR_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> (temp_q == $past(bus_wdata))); // R4

  always_comb begin
    if (rst_n && bus_rd && (bus_addr == RA_CTRL))
      AST_FORCE_RD_ZERO: assert (bus_rdata[NC:1] == '0); // R10
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ld,
  input  logic [WW-1:0] ld_val,
  input  logic          top_hit,
  output logic [WW-1:0] cnt_q,
  output logic          cmp_live
);
  logic [WW-1:0] cnt_d;
  logic          block_q, block_d;

  assign cmp_live = tick && !block_q;

  always_comb begin
    cnt_d = cnt_q;
    if (ld)           cnt_d = ld_val;
    else if (tick)    cnt_d = top_hit ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    block_d = block_q;
    if (ld)        block_d = 1'b1;
    else if (tick) block_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      block_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      block_q <= block_d;
    end
  end

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_q == $past(ld_val))); // R2

  AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> !cmp_live); // R8

  AST_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld && !top_hit && (cnt_q == '1)) |=> (cnt_q == '0)); // R5

  AST_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (top_hit && !ld) |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_ld,
  input  logic [WW-1:0] ld_val,
  input  logic [WW-1:0] cnt,
  input  logic          cmp_live,
  input  logic          force_stb,
  input  logic          flag_clr,
  output logic [WW-1:0] cmp_q,
  output logic          match,
  output logic          flag_q,
  output logic          wave_q
);
  logic [WW-1:0] cmp_d;
  logic          flag_d, wave_d;

  assign match = cmp_live && (cnt == cmp_q);

  always_comb begin
    cmp_d  = cmp_ld ? ld_val : cmp_q;
    flag_d = match || (flag_q && !flag_clr);
    wave_d = wave_q ^ (match || force_stb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      flag_q <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      flag_q <= flag_d;
      wave_q <= wave_d;
    end
  end

  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag_q); // R7

  AST_WAVE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (match || force_stb) |=> (wave_q != $past(wave_q))); // R7

  AST_WAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(match || force_stb) |=> $stable(wave_q)); // R9

  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (force_stb && !match && !flag_q) |=> !flag_q); // R9

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !match) |=> !flag_q); // R11
endmodule

// File: rtl/byte_timer16.sv
module byte_timer16
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [NCH-1:0]    cmp_flag,
  output logic [NCH-1:0]    cmp_wave
);
  logic [1:0]               rst_sync_q;
  logic                     rst_int_n;
  logic [WORD_W-1:0]        cnt, word_val;
  logic [NCH-1:0][WORD_W-1:0] cmp_val;
  logic [NCH-1:0]           cmp_ld, force_stb, flag_clr, match;
  logic                     cnt_ld, mode_top, cmp_live, top_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tmr_bus_if #(.BW(BYTE_W), .NC(NCH)) u_bus (
    .clk(clk), .rst_n(rst_int_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_val(cnt), .cmp_val(cmp_val), .flag_val(cmp_flag),
    .word_val(word_val), .cnt_ld(cnt_ld), .cmp_ld(cmp_ld),
    .force_stb(force_stb), .flag_clr(flag_clr), .mode_top(mode_top)
  );

  assign top_hit = mode_top && match[0];

  tmr_counter #(.WW(WORD_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick(tick),
    .ld(cnt_ld), .ld_val(word_val), .top_hit(top_hit),
    .cnt_q(cnt), .cmp_live(cmp_live)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_channel #(.WW(WORD_W)) u_ch (
      .clk(clk), .rst_n(rst_int_n),
      .cmp_ld(cmp_ld[i]), .ld_val(word_val),
      .cnt(cnt), .cmp_live(cmp_live),
      .force_stb(force_stb[i]), .flag_clr(flag_clr[i]),
      .cmp_q(cmp_val[i]), .match(match[i]),
      .flag_q(cmp_flag[i]), .wave_q(cmp_wave[i])
    );
  end

  AST_FORCE_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|force_stb && !tick && !cnt_ld) |=> $stable(cnt)); // R9
endmodule

// File: tb/byte_timer16_test.sv
module byte_timer16_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] cmp_flag, cmp_wave;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  byte_timer16 uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_flag(cmp_flag), .cmp_wave(cmp_wave)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr16(input logic [2:0] lo_addr, input logic [15:0] v);
    wr(lo_addr + 3'd1, v[15:8]);
    wr(lo_addr, v[7:0]);
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd0, lo);
    rd(3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic rd_cmp(input logic [2:0] lo_addr, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(lo_addr, lo);
    rd(lo_addr + 3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    logic [7:0] b;
    rd_cnt(v);          check("R1 counter", v, 16'h0000);
    rd_cmp(3'd2, v);    check("R1 compare A", v, 16'h0000);
    rd_cmp(3'd4, v);    check("R1 compare B", v, 16'h0000);
    rd(3'd6, b);        check("R1 control", {8'h00, b}, 16'h0000);
    check("R1 flags", {14'd0, cmp_flag}, 16'h0000);
    check("R1 waves", {14'd0, cmp_wave}, 16'h0000);
  endtask

  task automatic t_atomic_write;
    logic [15:0] v;
    wr(3'd3, 8'hAB);
    rd_cmp(3'd2, v);    check("R2 high byte alone does not commit", v, 16'h0000);
    wr(3'd2, 8'hCD);
    rd_cmp(3'd2, v);    check("R2 compare A committed", v, 16'hABCD);
    wr16(3'd0, 16'h1234);
    rd_cnt(v);          check("R2 counter committed", v, 16'h1234);
  endtask

  task automatic t_read_snapshot;
    logic [7:0] b;
    wr16(3'd0, 16'h00FF);
    rd(3'd0, b);        check("R3 low byte read", {8'h00, b}, 16'h00FF);
    ticks(1);
    rd(3'd1, b);        check("R3 high byte from snapshot", {8'h00, b}, 16'h0000);
    rd(3'd0, b);        check("R3 low after tick", {8'h00, b}, 16'h0000);
    rd(3'd1, b);        check("R3 high after tick", {8'h00, b}, 16'h0001);
  endtask

  task automatic t_shared_temp;
    logic [15:0] v;
    logic [7:0] b;
    rd(3'd0, b);
    wr(3'd4, 8'h55);
    rd_cmp(3'd4, v);    check("R4 counter snapshot reused by compare B", v, 16'h0155);
  endtask

  task automatic t_rollover;
    logic [15:0] v;
    wr16(3'd0, 16'hFFFE);
    ticks(2);
    rd_cnt(v);          check("R5 rollover", v, 16'h0000);
    ticks(3);
    rd_cnt(v);          check("R5 increment", v, 16'h0003);
  endtask

  task automatic t_match;
    logic [7:0] b;
    wr(3'd7, 8'h03);
    wr16(3'd2, 16'h0010);
    wr16(3'd4, 16'h0012);
    wr16(3'd0, 16'h000F);
    ticks(2);
    check("R7 flag A set", {14'd0, cmp_flag}, 16'h0001);
    check("R7 wave A toggled", {14'd0, cmp_wave}, 16'h0001);
    ticks(2);
    rd(3'd7, b);        check("R7 flag register", {8'h00, b}, 16'h0003);
    check("R7 wave B toggled", {14'd0, cmp_wave}, 16'h0003);
    wr(3'd7, 8'h01);
    check("R11 clear flag A only", {14'd0, cmp_flag}, 16'h0002);
    wr(3'd7, 8'h00);
    check("R11 zero write keeps flags", {14'd0, cmp_flag}, 16'h0002);
    wr(3'd7, 8'h02);
    check("R11 clear flag B", {14'd0, cmp_flag}, 16'h0000);
  endtask

  task automatic t_block;
    logic [15:0] v;
    wr16(3'd4, 16'h0011);
    wr16(3'd0, 16'h0010);
    ticks(1);
    check("R8 blocked match keeps flags", {14'd0, cmp_flag}, 16'h0000);
    check("R8 blocked match keeps waves", {14'd0, cmp_wave}, 16'h0003);
    rd_cnt(v);          check("R8 counter still advanced", v, 16'h0011);
    ticks(1);
    check("R8 block lasts one tick", {14'd0, cmp_flag}, 16'h0002);
    check("R8 wave B toggled after block", {14'd0, cmp_wave}, 16'h0001);
  endtask

  task automatic t_top_mode;
    logic [15:0] v;
    wr(3'd6, 8'h01);
    wr16(3'd2, 16'h0005);
    wr(3'd7, 8'h03);
    wr16(3'd0, 16'h0003);
    ticks(3);
    rd_cnt(v);          check("R6 clear at compare A", v, 16'h0000);
    check("R6 flag A on top", {14'd0, cmp_flag}, 16'h0001);
    check("R6 wave A toggled", {14'd0, cmp_wave}, 16'h0000);
    wr16(3'd0, 16'h0005);
    ticks(1);
    rd_cnt(v);          check("R8 clear suppressed after load", v, 16'h0006);
  endtask

  task automatic t_force;
    logic [15:0] v;
    logic [7:0] b;
    wr(3'd7, 8'h03);
    wr16(3'd0, 16'h0005);
    wr(3'd6, 8'h03);
    check("R9 force A toggles wave", {14'd0, cmp_wave}, 16'h0001);
    check("R9 force A sets no flag", {14'd0, cmp_flag}, 16'h0000);
    rd_cnt(v);          check("R9 force keeps counter", v, 16'h0005);
    rd(3'd6, b);        check("R10 control reads mode only", {8'h00, b}, 16'h0001);
    wr(3'd6, 8'h05);
    check("R9 force B toggles wave", {14'd0, cmp_wave}, 16'h0003);
    check("R9 force B sets no flag", {14'd0, cmp_flag}, 16'h0000);
    wr(3'd6, 8'h06);
    rd(3'd6, b);        check("R10 strobes read zero", {8'h00, b}, 16'h0000);
    check("R9 force both", {14'd0, cmp_wave}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_atomic_write();
    t_read_snapshot();
    t_shared_temp();
    t_rollover();
    t_match();
    t_block();
    t_top_mode();
    t_force();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule